// File: doc/BRIEF.md
# Low-Power Mode Pin Controller

This block sequences an 8051-style core through its three operating states (running, idle and power-down) and sets the external bus pins to match each state. Software asks for a low-power state by writing the power-control bits. The request takes effect only when the instruction that made the write reports completion. Idle gates the CPU clock and leaves the oscillator running. Power-down also stops the oscillator and ignores every interrupt; only the hardware reset pin ends it.

While running, the address-latch strobe, the program-store strobe and ports 0 and 2 carry whatever the core drives. In a low-power state the pins are overridden. Both strobes sit high in idle and low in power-down. Port behaviour depends on where code was executing when the state was entered. With internal code, ports 0 and 2 show their latch data. With external code, port 0 floats and port 2 shows the held high address byte in idle. In power-down, port 2 shows its latch data instead, and every latch bit of 1 is held by the strong pull-up. After the reset pin is released, the internal reset stays asserted for a programmable number of oscillator cycles, which models the oscillator settling time.

Top module: `lpm_pin_ctrl`

## Requirements
- R1: Counting from release of `rst_pin_n` (active low), `rst_int_o` stays high for exactly `osc_wait_i`+1 rising clock edges and then falls. `osc_run_o` is high the whole time.
- R2: A power-control write (`pcon_wr_i` with `pcon_bits_i`, bit 0 = idle request, bit 1 = power-down request) is held pending. The requested state is entered on the first rising edge at which `insn_done_i` is high, which may be the same edge as the write. Before that edge the block stays in the running state.
- R3: In power-down, `pd_o`=1, `osc_run_o`=0 and `cpu_clk_en_o`=0.
- R4: `irq_i` has no effect in power-down. Only asserting `rst_pin_n` low leaves it, after which the R1 sequence runs and the block ends up running.
- R5: A request with only bit 0 set enters idle, where `idle_o`=1, `cpu_clk_en_o`=0 and `osc_run_o`=1.
- R6: `irq_i` high at a rising edge in idle returns the block to the running state at that edge.
- R7: A write with both bits set enters power-down, not idle.
- R8: `ale_o` and `psen_o` are 1 in idle and 0 in power-down. In the running state and during internal reset they equal `ale_core_i` and `psen_core_i`.
- R9: In idle or power-down, `p0_oe_o` is 0 (port floats) if code was external, else `p0_oe_o`=1 and `p0_o`=`p0_latch_i`. While running, `p0_o`/`p0_oe_o` pass the core values.
- R10: In a low-power state, `p2_o` equals `p2_latch_i` for internal code, equals `p2_addr_i` for external code in idle, and equals `p2_latch_i` for external code in power-down. `p2_strong_o` equals `p2_latch_i` only in power-down entered from external code and is 0 otherwise. While running, `p2_o` passes `p2_core_i`.
- R11: The code location (`ext_code_i`, 1 = external) is captured when a low-power state is entered. Changing it during that state does not alter the pins.
- R12: Asserting `rst_pin_n` clears a pending request, so a later `insn_done_i` causes no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_pin_n | input | 1 | Hardware reset pin, active low, asynchronous |
| osc_wait_i | input | WAIT_W | Oscillator settle count in clock cycles |
| pcon_wr_i | input | 1 | Power-control register write strobe |
| pcon_bits_i | input | 2 | Written bits: [0] idle, [1] power-down |
| insn_done_i | input | 1 | Current instruction completes this cycle |
| irq_i | input | 1 | Enabled interrupt pending |
| ext_code_i | input | 1 | 1 = executing from external program memory |
| ale_core_i | input | 1 | Core address-latch strobe |
| psen_core_i | input | 1 | Core program-store strobe |
| p0_core_i | input | P0_W | Core port 0 output value |
| p0_core_oe_i | input | 1 | Core port 0 drive enable |
| p2_core_i | input | P2_W | Core port 2 output value |
| p0_latch_i | input | P0_W | Port 0 latch contents |
| p2_latch_i | input | P2_W | Port 2 latch contents |
| p2_addr_i | input | P2_W | Held high address byte |
| rst_int_o | output | 1 | Internal reset to the core |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| osc_run_o | output | 1 | Oscillator run enable |
| idle_o | output | 1 | Idle state flag |
| pd_o | output | 1 | Power-down state flag |
| ale_o | output | 1 | Address-latch strobe pin value |
| psen_o | output | 1 | Program-store strobe pin value |
| p0_o | output | P0_W | Port 0 pin value |
| p0_oe_o | output | 1 | Port 0 drive enable, 0 = float |
| p2_o | output | P2_W | Port 2 pin value |
| p2_strong_o | output | P2_W | Per-bit strong pull-up hold on port 2 |

## Verification
Each of the three request encodings is crossed with both code locations and with four latch patterns: all zeros, all ones and two mixed values. The mixed patterns separate a port-2 output taken from the latch from one taken from the address byte or the core, and they expose strong pull-up bits that follow the wrong source. Settle counts from 0 to 6 distinguish an off-by-one in the reset stretch from a correct count. Interrupts offered in both low-power states separate the state that wakes from the one that must not. Flipping the code location during a low-power state tells a captured location apart from a live one. A same-edge write and completion, and a reset that lands between a write and its completion, cover the timing of the request latch.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    ST_WAKE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_IDLE  = 2'd2,
    ST_PDOWN = 2'd3
  } lpm_state_e;

  localparam int unsigned REQ_IDLE_BIT = 0;
  localparam int unsigned REQ_PD_BIT   = 1;
  localparam int unsigned REQ_W        = 2;
endpackage

// File: rtl/lpm_req_latch.sv
module lpm_req_latch
  import lpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [REQ_W-1:0] bits_i,
  input  logic             take_i,
  output logic             want_idle_o,
  output logic             want_pd_o
);
  logic [REQ_W-1:0] pend_q;
  logic [REQ_W-1:0] eff;

  // a write in the current cycle overrides the held request
  assign eff         = wr_i ? bits_i : pend_q;
  assign want_idle_o = eff[REQ_IDLE_BIT];
  assign want_pd_o   = eff[REQ_PD_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (take_i)  pend_q <= '0;
    else if (wr_i)    pend_q <= bits_i;
  end
endmodule

// File: rtl/lpm_osc_timer.sv
module lpm_osc_timer #(
  parameter int unsigned WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic              done_o
);
  logic [WAIT_W-1:0] cnt_q;

  assign done_o = run_i && (cnt_q >= wait_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run_i)           cnt_q <= '0;
    else if (!done_o)          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       settled_i,
  input  logic       want_idle_i,
  input  logic       want_pd_i,
  input  logic       insn_done_i,
  input  logic       irq_i,
  input  logic       ext_code_i,
  output lpm_state_e state_o,
  output logic       ext_q_o,
  output logic       take_o
);
  lpm_state_e state_q, state_d;
  logic       ext_q;

  assign take_o = (state_q == ST_RUN) && insn_done_i && (want_idle_i || want_pd_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAKE:  if (settled_i) state_d = ST_RUN;
      ST_RUN:   if (take_o)    state_d = want_pd_i ? ST_PDOWN : ST_IDLE;
      ST_IDLE:  if (irq_i)     state_d = ST_RUN;
      ST_PDOWN: state_d = ST_PDOWN;
      default:  state_d = ST_WAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAKE;
      ext_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take_o) ext_q <= ext_code_i;
    end
  end

  assign state_o = state_q;
  assign ext_q_o = ext_q;
endmodule

// File: rtl/lpm_pin_mux.sv
module lpm_pin_mux
  import lpm_pkg::*;
#(
  parameter int unsigned P0_W = 8,
  parameter int unsigned P2_W = 8
) (
  input  lpm_state_e      state_i,
  input  logic            ext_i,
  input  logic            ale_core_i,
  input  logic            psen_core_i,
  input  logic [P0_W-1:0] p0_core_i,
  input  logic            p0_core_oe_i,
  input  logic [P2_W-1:0] p2_core_i,
  input  logic [P0_W-1:0] p0_latch_i,
  input  logic [P2_W-1:0] p2_latch_i,
  input  logic [P2_W-1:0] p2_addr_i,
  output logic            ale_o,
  output logic            psen_o,
  output logic [P0_W-1:0] p0_o,
  output logic            p0_oe_o,
  output logic [P2_W-1:0] p2_o,
  output logic [P2_W-1:0] p2_strong_o
);
  logic low_pwr, in_pd, hold_strong;

  assign in_pd       = (state_i == ST_PDOWN);
  assign low_pwr     = in_pd || (state_i == ST_IDLE);
  assign hold_strong = in_pd && ext_i;

  always_comb begin
    if (!low_pwr) begin
      ale_o   = ale_core_i;
      psen_o  = psen_core_i;
      p0_o    = p0_core_i;
      p0_oe_o = p0_core_oe_i;
      p2_o    = p2_core_i;
    end else begin
      ale_o   = !in_pd;
      psen_o  = !in_pd;
      p0_o    = ext_i ? '0 : p0_latch_i;
      p0_oe_o = !ext_i;
      p2_o    = (ext_i && !in_pd) ? p2_addr_i : p2_latch_i;
    end
  end

  for (genvar b = 0; b < P2_W; b++) begin : g_strong
    assign p2_strong_o[b] = hold_strong && p2_latch_i[b];
  end
endmodule

// File: rtl/lpm_pin_ctrl.sv
module lpm_pin_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned P0_W   = 8,
  parameter int unsigned P2_W   = 8,
  parameter int unsigned WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_pin_n,
  input  logic [WAIT_W-1:0] osc_wait_i,
  input  logic              pcon_wr_i,
  input  logic [1:0]        pcon_bits_i,
  input  logic              insn_done_i,
  input  logic              irq_i,
  input  logic              ext_code_i,
  input  logic              ale_core_i,
  input  logic              psen_core_i,
  input  logic [P0_W-1:0]   p0_core_i,
  input  logic              p0_core_oe_i,
  input  logic [P2_W-1:0]   p2_core_i,
  input  logic [P0_W-1:0]   p0_latch_i,
  input  logic [P2_W-1:0]   p2_latch_i,
  input  logic [P2_W-1:0]   p2_addr_i,
  output logic              rst_int_o,
  output logic              cpu_clk_en_o,
  output logic              osc_run_o,
  output logic              idle_o,
  output logic              pd_o,
  output logic              ale_o,
  output logic              psen_o,
  output logic [P0_W-1:0]   p0_o,
  output logic              p0_oe_o,
  output logic [P2_W-1:0]   p2_o,
  output logic [P2_W-1:0]   p2_strong_o
);
  lpm_state_e state;
  logic       ext_q, take, settled, want_idle, want_pd, waking;

  assign waking = (state == ST_WAKE);

  lpm_req_latch u_req (
    .clk        (clk),
    .rst_n      (rst_pin_n),
    .wr_i       (pcon_wr_i),
    .bits_i     (pcon_bits_i),
    .take_i     (take),
    .want_idle_o(want_idle),
    .want_pd_o  (want_pd)
  );

  lpm_osc_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_pin_n),
    .run_i (waking),
    .wait_i(osc_wait_i),
    .done_o(settled)
  );

  lpm_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_pin_n),
    .settled_i  (settled),
    .want_idle_i(want_idle),
    .want_pd_i  (want_pd),
    .insn_done_i(insn_done_i),
    .irq_i      (irq_i),
    .ext_code_i (ext_code_i),
    .state_o    (state),
    .ext_q_o    (ext_q),
    .take_o     (take)
  );

  lpm_pin_mux #(.P0_W(P0_W), .P2_W(P2_W)) u_pins (
    .state_i     (state),
    .ext_i       (ext_q),
    .ale_core_i  (ale_core_i),
    .psen_core_i (psen_core_i),
    .p0_core_i   (p0_core_i),
    .p0_core_oe_i(p0_core_oe_i),
    .p2_core_i   (p2_core_i),
    .p0_latch_i  (p0_latch_i),
    .p2_latch_i  (p2_latch_i),
    .p2_addr_i   (p2_addr_i),
    .ale_o       (ale_o),
    .psen_o      (psen_o),
    .p0_o        (p0_o),
    .p0_oe_o     (p0_oe_o),
    .p2_o        (p2_o),
    .p2_strong_o (p2_strong_o)
  );

  assign rst_int_o    = waking;
  assign idle_o       = (state == ST_IDLE);
  assign pd_o         = (state == ST_PDOWN);
  assign osc_run_o    = (state != ST_PDOWN);
  assign cpu_clk_en_o = (state == ST_RUN) || waking;
endmodule

// File: rtl/lpm_pin_ctrl_chk.sv
module lpm_pin_ctrl_chk (
  input logic clk,
  input logic rst_pin_n,
  input logic insn_done_i,
  input logic irq_i,
  input logic rst_int_o,
  input logic cpu_clk_en_o,
  input logic osc_run_o,
  input logic idle_o,
  input logic pd_o,
  input logic ale_o,
  input logic psen_o
);
  AST_RST_OSC_ON: assert property (@(posedge clk) disable iff (!rst_pin_n)
    rst_int_o |-> osc_run_o); // R1

  AST_ENTRY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_pin_n)
    ($rose(pd_o) || $rose(idle_o)) |-> $past(insn_done_i)); // R2

  AST_PD_CLOCKS_OFF: assert property (@(posedge clk) disable iff (!rst_pin_n)
    pd_o |-> (!osc_run_o && !cpu_clk_en_o)); // R3

  AST_PD_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (pd_o && irq_i) |=> pd_o); // R4

  AST_IDLE_GATED: assert property (@(posedge clk) disable iff (!rst_pin_n)
    idle_o |-> (osc_run_o && !cpu_clk_en_o)); // R5

  AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (idle_o && irq_i) |=> !idle_o); // R6

  AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (!rst_pin_n)
    idle_o |-> (ale_o && psen_o)); // R8

  AST_PD_STROBES: assert property (@(posedge clk) disable iff (!rst_pin_n)
    pd_o |-> (!ale_o && !psen_o)); // R8

  AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $onehot0({idle_o, pd_o, rst_int_o})); // R2
endmodule

bind lpm_pin_ctrl lpm_pin_ctrl_chk u_chk (.*);

// File: tb/lpm_pin_ctrl_bench.sv
module lpm_pin_ctrl_bench;
  localparam int P0_W = 8, P2_W = 8, WAIT_W = 8;

  logic clk = 1'b0;
  logic rst_pin_n = 1'b0;
  logic [WAIT_W-1:0] osc_wait_i = '0;
  logic pcon_wr_i = 1'b0;
  logic [1:0] pcon_bits_i = '0;
  logic insn_done_i = 1'b0, irq_i = 1'b0, ext_code_i = 1'b0;
  logic ale_core_i = 1'b0, psen_core_i = 1'b1, p0_core_oe_i = 1'b1;
  logic [P0_W-1:0] p0_core_i = 8'h11, p0_latch_i = '0;
  logic [P2_W-1:0] p2_core_i = 8'h22, p2_latch_i = '0, p2_addr_i = '0;
  logic rst_int_o, cpu_clk_en_o, osc_run_o, idle_o, pd_o, ale_o, psen_o, p0_oe_o;
  logic [P0_W-1:0] p0_o;
  logic [P2_W-1:0] p2_o, p2_strong_o;

  int n_cmp = 0, n_bad = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  lpm_pin_ctrl #(.P0_W(P0_W), .P2_W(P2_W), .WAIT_W(WAIT_W)) u_lpm_pin_ctrl (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // mode: 0 running, 1 idle, 2 power-down
  task automatic chk_state(input string req, input int mode);
    chk({req, " idle"}, idle_o, mode == 1);
    chk({req, " pd"}, pd_o, mode == 2);
    chk({req, " osc"}, osc_run_o, mode != 2);
    chk({req, " clken"}, cpu_clk_en_o, mode == 0);
  endtask

  task automatic chk_pins(input string req, input int mode, input bit ext);
    logic [P0_W-1:0] e_p0; logic e_oe, e_ale; logic [P2_W-1:0] e_p2, e_st;
    if (mode == 0) begin
      e_ale = ale_core_i; e_p0 = p0_core_i; e_oe = p0_core_oe_i; e_p2 = p2_core_i; e_st = '0;
      chk({req, " psen"}, psen_o, psen_core_i);
    end else begin
      e_ale = (mode == 1);
      e_oe  = !ext;
      e_p0  = ext ? '0 : p0_latch_i;
      e_p2  = (ext && mode == 1) ? p2_addr_i : p2_latch_i;
      e_st  = (ext && mode == 2) ? p2_latch_i : '0;
      chk({req, " psen"}, psen_o, e_ale);
    end
    chk({req, " ale"}, ale_o, e_ale);
    chk({req, " p0oe"}, p0_oe_o, e_oe);
    if (e_oe) chk({req, " p0"}, p0_o, e_p0);
    chk({req, " p2"}, p2_o, e_p2);
    chk({req, " p2strong"}, p2_strong_o, e_st);
  endtask

  task automatic do_reset(input int w);
    int n = 0;
    @(negedge clk);
    rst_pin_n = 1'b0; osc_wait_i = WAIT_W'(w);
    @(negedge clk);
    chk("R1 osc in reset", osc_run_o, 1);
    chk("R1 rst_int in reset", rst_int_o, 1);
    rst_pin_n = 1'b1;
    while (rst_int_o === 1'b1 && n < 300) begin
      chk("R1 osc while settling", osc_run_o, 1);
      @(posedge clk); #1; n++;
    end
    chk("R1 reset stretch", n, w + 1);
    @(negedge clk);
  endtask

  task automatic request(input logic [1:0] bits, input int gap);
    pcon_wr_i = 1'b1; pcon_bits_i = bits;
    @(negedge clk);
    pcon_wr_i = 1'b0;
    for (int g = 0; g < gap; g++) begin
      chk("R2 still running before done", {idle_o, pd_o}, 0);
      @(negedge clk);
    end
    insn_done_i = 1'b1;
    @(negedge clk);
    insn_done_i = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] pats [4];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h3C;

    // reset state and settle-count sweep (R1)
    for (int w = 0; w <= 6; w++) begin
      do_reset(w);
      chk_state("R1 after reset", 0);
      chk_pins("R8 run pass-through", 0, 1'b0);
    end

    // request x location x pattern sweep
    for (int rq = 1; rq <= 3; rq++) begin
      for (int ex = 0; ex <= 1; ex++) begin
        for (int p = 0; p < 4; p++) begin
          int mode;
          do_reset(2);
          ext_code_i  = ex[0];
          p2_latch_i  = pats[p];
          p0_latch_i  = ~pats[p] ^ 8'h0F;
          p2_addr_i   = pats[(p + 1) % 4] ^ 8'h5A;
          p2_core_i   = pats[p] + 8'd7;
          ale_core_i  = p[0];
          psen_core_i = ~p[1];
          request(rq[1:0], p);
          mode = rq[1] ? 2 : 1;   // R7: both bits -> power-down
          chk_state(rq == 3 ? "R7 both bits" : (mode == 2 ? "R3 pd entry" : "R5 idle entry"), mode);
          chk_pins("R9 R10 R8 low-power pins", mode, ex[0]);
          // R11: location captured at entry
          ext_code_i = ~ex[0];
          @(negedge clk);
          chk_pins("R11 captured location", mode, ex[0]);
          // R6 / R4: interrupt
          irq_i = 1'b1;
          @(negedge clk);
          irq_i = 1'b0;
          if (mode == 1) begin
            chk_state("R6 idle wake on irq", 0);
            chk_pins("R6 pins after wake", 0, ex[0]);
          end else begin
            chk_state("R4 irq ignored in pd", 2);
            repeat (3) @(negedge clk);
            chk_state("R4 pd persists", 2);
          end
        end
      end
    end

    // R4: reset leaves power-down
    do_reset(1);
    request(2'b10, 0);
    chk_state("R4 pd before reset", 2);
    do_reset(3);
    chk_state("R4 running after reset", 0);

    // R2: write and completion on the same edge
    pcon_wr_i = 1'b1; pcon_bits_i = 2'b01; insn_done_i = 1'b1;
    @(negedge clk);
    pcon_wr_i = 1'b0; insn_done_i = 1'b0;
    chk_state("R2 same-edge entry", 1);

    // R12: reset drops a pending request
    do_reset(0);
    pcon_wr_i = 1'b1; pcon_bits_i = 2'b10;
    @(negedge clk);
    pcon_wr_i = 1'b0;
    do_reset(0);
    insn_done_i = 1'b1;
    @(negedge clk);
    insn_done_i = 1'b0;
    @(negedge clk);
    chk_state("R12 pending cleared by reset", 0);

    done_flag = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule